// File: doc/BRIEF.md
# Register Rename Mapping Tracker

This block records which in-flight writer currently owns each architectural register of a small register set with fixed aliasing. Registers are arranged in groups of nested widths: a wide register contains a middle-width field, which in turn contains a narrow field. When a write is announced, the register and every narrower field inside it take the writer's tag. The wider registers that contain it take the tag only when the write is a full update. A release from a finished writer clears only those entries that still hold that writer's tag. A lookup returns, one cycle later, the set of writer tags that a source operand depends on.

Alongside the table the block keeps occupancy bookkeeping. It holds the number of mappings in use, the peak of that number, and the lifetime count of mappings created. It also answers whether N further writes fit into the mapping pool. The pool size comes from a parameter. A request larger than the pool raises the pool, and a pool size of zero means the pool has no limit.

A write and a release may arrive in the same cycle. In that case the release is applied first and the write second, so the write wins on any shared entry.

Top module: `rename_map_tracker`

## Requirements
- R1: Register IDs from 1 upward form groups of three: the lowest ID of a group is the wide register, the next is the middle field and the highest is the narrow field. The sub-registers of a register are the higher IDs of its own group. An accepted write sets the named register and all of its sub-registers to the writer tag.
- R2: An accepted write with the full flag set also sets every super-register (the lower IDs of the same group) to the tag. With the full flag clear, super-register entries keep their previous owners.
- R3: A release whose register is currently mapped clears the named register and its sub-registers, but only the entries that hold exactly the released tag. Entries owned by other writers are kept.
- R4: A release with the full flag set also clears super-register entries that hold the released tag. With the full flag clear, super-registers are left alone.
- R5: A release of a register whose entry is unmapped (tag 0) changes no entry and leaves the used count unchanged. A release of a mapped register lowers the used count by one.
- R6: Each accepted write raises the used count and the created count by one. The peak count rises by one when the used count equalled the peak just before that write. The counts are visible on the cycle after the request.
- R7: An availability request for N answers ok, one cycle later, when N plus the used count is at most the pool size. If N exceeds the pool size, the pool size becomes N first.
- R8: A lookup of register R gives, one cycle later, a vector with bit t set for each tag t held by R or by any of R's sub-registers. Each tag is reported once, and bit 0 is never set.
- R9: Register ID 0 and writer tag 0 are reserved. A write naming either is ignored, a release naming ID 0 is ignored, and a lookup of ID 0 returns an empty vector.
- R10: With a pool size of zero, every availability request answers ok and the pool size stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write mapping request |
| wr_reg | input | ID_W | Register being written |
| wr_tag | input | TAG_W | Writer tag (0 reserved) |
| wr_full | input | 1 | Write fully updates enclosing registers |
| rel_valid | input | 1 | Release request |
| rel_reg | input | ID_W | Register of the releasing writer |
| rel_tag | input | TAG_W | Tag of the releasing writer |
| rel_full | input | 1 | Releasing writer was a full update |
| lk_reg | input | ID_W | Source register to look up |
| lk_deps | output | 2**TAG_W | Registered set of dependency tags |
| chk_valid | input | 1 | Availability request |
| chk_n | input | CNT_W | Number of new writes to fit |
| chk_ok | output | 1 | Registered availability answer |
| used_count | output | CNT_W | Mappings in use |
| peak_count | output | CNT_W | Highest used count seen |
| created_count | output | CNT_W | Mappings created since reset |
| pool_size | output | CNT_W | Current pool size (0 = unlimited) |

## Verification
Writes are issued at each alias level, with and without the full flag. Lookups of the wide, middle and narrow IDs then tell downward propagation apart from upward propagation, and show that a partial write leaves the wider owner in place. Releases are tried with a matching tag, with a foreign tag on a mapped register, and on unmapped registers. These cases separate tag-checked clearing from blind clearing and check the rule for lowering the used count. Availability requests below the pool, above it and over its size show the raise of the pool. A second instance with a zero pool covers the unlimited case. The reserved ID and the reserved tag are sent to show that they leave the table and the counters untouched.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
  // True when register b is a narrower field nested inside register a.
  function automatic logic is_sub(input int a, input int b, input int lv);
    if (a <= 0 || b <= 0) return 1'b0;
    return ((a - 1) / lv == (b - 1) / lv) && ((b - 1) % lv > (a - 1) % lv);
  endfunction
endpackage

// File: rtl/rmt_alias.sv
module rmt_alias #(
  parameter int NUM_REGS = 13,
  parameter int LEVELS   = 3,
  parameter int ID_W     = 4
) (
  input  logic [ID_W-1:0]     id,
  output logic [NUM_REGS-1:0] sub_m,
  output logic [NUM_REGS-1:0] sup_m
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    assign sub_m[i] = rmt_pkg::is_sub(int'(id), i, LEVELS);
    assign sup_m[i] = rmt_pkg::is_sub(i, int'(id), LEVELS);
  end
endmodule

// File: rtl/rmt_table.sv
module rmt_table #(
  parameter int NUM_REGS = 13,
  parameter int ID_W     = 4,
  parameter int TAG_W    = 4,
  localparam int NTAGS   = 1 << TAG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ID_W-1:0]     wr_reg,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic                wr_full,
  input  logic [NUM_REGS-1:0] wr_sub,
  input  logic [NUM_REGS-1:0] wr_sup,
  input  logic                rel_en,
  input  logic [ID_W-1:0]     rel_reg,
  input  logic [TAG_W-1:0]    rel_tag,
  input  logic                rel_full,
  input  logic [NUM_REGS-1:0] rel_sub,
  input  logic [NUM_REGS-1:0] rel_sup,
  input  logic [ID_W-1:0]     lk_reg,
  input  logic [NUM_REGS-1:0] lk_sub,
  output logic                rel_hit,
  output logic [NTAGS-1:0]    lk_deps
);
  logic [TAG_W-1:0] map_q [NUM_REGS];
  logic [TAG_W-1:0] map_d [NUM_REGS];
  logic [NTAGS-1:0] deps_d;

  always_comb begin
    rel_hit = 1'b0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rel_en && rel_reg == ID_W'(i) && map_q[i] != '0) rel_hit = 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      map_d[i] = map_q[i];
      if (rel_hit && map_q[i] == rel_tag &&
          (rel_reg == ID_W'(i) || rel_sub[i] || (rel_full && rel_sup[i])))
        map_d[i] = '0;
      if (wr_en && (wr_reg == ID_W'(i) || wr_sub[i] || (wr_full && wr_sup[i])))
        map_d[i] = wr_tag;
    end
  end

  always_comb begin
    deps_d = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if ((lk_reg == ID_W'(i) || lk_sub[i]) && map_q[i] != '0)
        deps_d[map_q[i]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) map_q[i] <= '0;
      lk_deps <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) map_q[i] <= map_d[i];
      lk_deps <= deps_d;
    end
  end
endmodule

// File: rtl/rmt_count.sv
module rmt_count #(
  parameter int CNT_W     = 8,
  parameter int POOL_SIZE = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  input  logic             chk_valid,
  input  logic [CNT_W-1:0] chk_n,
  output logic             chk_ok,
  output logic [CNT_W-1:0] used_q,
  output logic [CNT_W-1:0] peak_q,
  output logic [CNT_W-1:0] total_q,
  output logic [CNT_W-1:0] pool_q
);
  logic             dec_ok;
  logic [CNT_W-1:0] eff_pool;
  logic [CNT_W:0]   need;
  logic             ok_d;

  assign dec_ok   = dec && used_q != '0;
  assign eff_pool = (chk_n > pool_q) ? chk_n : pool_q;
  assign need     = {1'b0, chk_n} + {1'b0, used_q};
  assign ok_d     = (pool_q == '0) || (need <= {1'b0, eff_pool});

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q  <= '0;
      peak_q  <= '0;
      total_q <= '0;
      pool_q  <= CNT_W'(POOL_SIZE);
      chk_ok  <= 1'b0;
    end else begin
      if (inc && !dec_ok)      used_q <= used_q + 1'b1;
      else if (!inc && dec_ok) used_q <= used_q - 1'b1;
      if (inc) total_q <= total_q + 1'b1;
      if (inc && used_q == peak_q) peak_q <= peak_q + 1'b1;
      if (chk_valid) begin
        chk_ok <= ok_d;
        if (pool_q != '0 && chk_n > pool_q) pool_q <= chk_n;
      end
    end
  end
endmodule

// File: rtl/rename_map_tracker.sv
module rename_map_tracker #(
  parameter int GROUPS    = 4,
  parameter int LEVELS    = 3,
  parameter int TAG_W     = 4,
  parameter int CNT_W     = 8,
  parameter int POOL_SIZE = 6,
  localparam int NUM_REGS = GROUPS * LEVELS + 1,
  localparam int ID_W     = $clog2(NUM_REGS),
  localparam int NTAGS    = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [ID_W-1:0]  wr_reg,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_full,
  input  logic             rel_valid,
  input  logic [ID_W-1:0]  rel_reg,
  input  logic [TAG_W-1:0] rel_tag,
  input  logic             rel_full,
  input  logic [ID_W-1:0]  lk_reg,
  output logic [NTAGS-1:0] lk_deps,
  input  logic             chk_valid,
  input  logic [CNT_W-1:0] chk_n,
  output logic             chk_ok,
  output logic [CNT_W-1:0] used_count,
  output logic [CNT_W-1:0] peak_count,
  output logic [CNT_W-1:0] created_count,
  output logic [CNT_W-1:0] pool_size
);
  logic [NUM_REGS-1:0] wr_sub, wr_sup, rel_sub, rel_sup, lk_sub, lk_sup;
  logic wr_en, rel_en, rel_hit;

  assign wr_en  = wr_valid && wr_reg != '0 && wr_tag != '0 &&
                  int'(wr_reg) < NUM_REGS;
  assign rel_en = rel_valid && rel_reg != '0 && int'(rel_reg) < NUM_REGS;

  rmt_alias #(.NUM_REGS(NUM_REGS), .LEVELS(LEVELS), .ID_W(ID_W)) u_al_wr (
    .id(wr_reg), .sub_m(wr_sub), .sup_m(wr_sup));
  rmt_alias #(.NUM_REGS(NUM_REGS), .LEVELS(LEVELS), .ID_W(ID_W)) u_al_rel (
    .id(rel_reg), .sub_m(rel_sub), .sup_m(rel_sup));
  rmt_alias #(.NUM_REGS(NUM_REGS), .LEVELS(LEVELS), .ID_W(ID_W)) u_al_lk (
    .id(lk_reg), .sub_m(lk_sub), .sup_m(lk_sup));

  rmt_table #(.NUM_REGS(NUM_REGS), .ID_W(ID_W), .TAG_W(TAG_W)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_tag(wr_tag), .wr_full(wr_full),
    .wr_sub(wr_sub), .wr_sup(wr_sup),
    .rel_en(rel_en), .rel_reg(rel_reg), .rel_tag(rel_tag), .rel_full(rel_full),
    .rel_sub(rel_sub), .rel_sup(rel_sup),
    .lk_reg(lk_reg), .lk_sub(lk_sub),
    .rel_hit(rel_hit), .lk_deps(lk_deps));

  rmt_count #(.CNT_W(CNT_W), .POOL_SIZE(POOL_SIZE)) u_count (
    .clk(clk), .rst(rst), .inc(wr_en), .dec(rel_hit),
    .chk_valid(chk_valid), .chk_n(chk_n), .chk_ok(chk_ok),
    .used_q(used_count), .peak_q(peak_count), .total_q(created_count),
    .pool_q(pool_size));

  // Super-register mask of lookups is not needed.
  logic unused_lk;
  assign unused_lk = ^lk_sup;
endmodule

// File: rtl/rmt_checker.sv
module rmt_checker #(
  parameter int ID_W  = 4,
  parameter int TAG_W = 4,
  parameter int CNT_W = 8,
  localparam int NTAGS = 1 << TAG_W
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_valid,
  input logic [ID_W-1:0]  wr_reg,
  input logic [TAG_W-1:0] wr_tag,
  input logic             rel_valid,
  input logic [NTAGS-1:0] lk_deps,
  input logic [CNT_W-1:0] used_count,
  input logic [CNT_W-1:0] peak_count,
  input logic [CNT_W-1:0] created_count,
  input logic [CNT_W-1:0] pool_size
);
  p_create_count_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_reg != '0 && wr_tag != '0) |=>
      created_count == $past(created_count) + 1'b1);

  p_reserved_id_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_reg == '0) |=> created_count == $past(created_count));

  p_used_le_peak_r6: assert property (@(posedge clk) disable iff (rst)
    used_count <= peak_count);

  p_no_tag0_r8: assert property (@(posedge clk) disable iff (rst)
    !lk_deps[0]);

  p_pool_grows_r7: assert property (@(posedge clk) disable iff (rst)
    pool_size >= $past(pool_size));

  p_release_no_grow_r5: assert property (@(posedge clk) disable iff (rst)
    (rel_valid && !wr_valid) |=> used_count <= $past(used_count));
endmodule

bind rename_map_tracker rmt_checker #(.ID_W(ID_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_tag(wr_tag),
  .rel_valid(rel_valid), .lk_deps(lk_deps), .used_count(used_count),
  .peak_count(peak_count), .created_count(created_count), .pool_size(pool_size));

// File: tb/tb_rename_map_tracker.sv
`timescale 1ns/1ps
module tb_rename_map_tracker;
  localparam int ID_W = 4, TAG_W = 4, CNT_W = 8, NT = 16;

  logic clk = 0, rst = 1;
  always #2.5 clk = ~clk;

  logic wr_valid = 0, wr_full = 0, rel_valid = 0, rel_full = 0, chk_valid = 0;
  logic [ID_W-1:0] wr_reg = 0, rel_reg = 0, lk_reg = 0;
  logic [TAG_W-1:0] wr_tag = 0, rel_tag = 0;
  logic [CNT_W-1:0] chk_n = 0;
  logic [NT-1:0] lk_deps, lk_deps_u;
  logic chk_ok, chk_ok_u;
  logic [CNT_W-1:0] used_count, peak_count, created_count, pool_size;
  logic [CNT_W-1:0] used_u, peak_u, created_u, pool_u;

  rename_map_tracker dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_tag(wr_tag),
    .wr_full(wr_full), .rel_valid(rel_valid), .rel_reg(rel_reg), .rel_tag(rel_tag),
    .rel_full(rel_full), .lk_reg(lk_reg), .lk_deps(lk_deps), .chk_valid(chk_valid),
    .chk_n(chk_n), .chk_ok(chk_ok), .used_count(used_count), .peak_count(peak_count),
    .created_count(created_count), .pool_size(pool_size));

  rename_map_tracker #(.POOL_SIZE(0)) dut_unl (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_tag(wr_tag),
    .wr_full(wr_full), .rel_valid(rel_valid), .rel_reg(rel_reg), .rel_tag(rel_tag),
    .rel_full(rel_full), .lk_reg(lk_reg), .lk_deps(lk_deps_u), .chk_valid(chk_valid),
    .chk_n(chk_n), .chk_ok(chk_ok_u), .used_count(used_u), .peak_count(peak_u),
    .created_count(created_u), .pool_size(pool_u));

  int checks = 0, failures = 0;
  int exp_used = 0, exp_peak = 0, exp_total = 0, exp_pool = 6;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NT-1:0] tags(input int a, input int b);
    logic [NT-1:0] v = '0;
    if (a > 0) v[a] = 1'b1;
    if (b > 0) v[b] = 1'b1;
    return v;
  endfunction

  task automatic do_write(input int r, input int t, input logic full);
    wr_valid = 1; wr_reg = ID_W'(r); wr_tag = TAG_W'(t); wr_full = full;
    @(negedge clk);
    wr_valid = 0;
    if (r != 0 && t != 0) begin
      if (exp_used == exp_peak) exp_peak++;
      exp_used++; exp_total++;
    end
  endtask

  task automatic do_release(input int r, input int t, input logic full, input logic mapped);
    rel_valid = 1; rel_reg = ID_W'(r); rel_tag = TAG_W'(t); rel_full = full;
    @(negedge clk);
    rel_valid = 0;
    if (mapped) exp_used--;
  endtask

  task automatic lookup(input string req, input int r, input logic [NT-1:0] exp);
    lk_reg = ID_W'(r);
    @(negedge clk);
    check(req, $sformatf("lookup reg %0d", r), int'(lk_deps), int'(exp));
  endtask

  task automatic counts(input string req);
    check(req, "used", int'(used_count), exp_used);
    check(req, "peak", int'(peak_count), exp_peak);
    check(req, "created", int'(created_count), exp_total);
  endtask

  task automatic avail(input string req, input int n);
    logic exp_ok;
    if (n > exp_pool) exp_pool = n;
    exp_ok = (n + exp_used) <= exp_pool;
    chk_valid = 1; chk_n = CNT_W'(n);
    @(negedge clk);
    chk_valid = 0;
    check(req, $sformatf("chk_ok n=%0d", n), int'(chk_ok), int'(exp_ok));
    check(req, "pool_size", int'(pool_size), exp_pool);
    check("R10", "unlimited chk_ok", int'(chk_ok_u), 1);
    check("R10", "unlimited pool", int'(pool_u), 0);
  endtask

  task automatic t_reset;
    lookup("R8", 1, '0);
    counts("R6");
    check("R7", "reset pool", int'(pool_size), 6);
  endtask

  task automatic t_sub_r1;
    do_write(1, 5, 0);
    counts("R6");
    lookup("R1", 2, tags(5, 0));
    lookup("R1", 3, tags(5, 0));
  endtask

  task automatic t_super_r2;
    do_write(3, 7, 0);
    lookup("R2", 3, tags(7, 0));
    lookup("R8", 1, tags(5, 7));
    lookup("R8", 2, tags(5, 7));
    do_write(5, 9, 1);
    lookup("R2", 4, tags(9, 0));
    do_write(6, 11, 0);
    lookup("R2", 4, tags(9, 11));
    lookup("R2", 5, tags(9, 11));
    counts("R6");
  endtask

  task automatic t_release_r3;
    do_release(1, 5, 0, 1);
    lookup("R3", 1, tags(7, 0));
    lookup("R3", 3, tags(7, 0));
    counts("R5");
  endtask

  task automatic t_release_full_r4;
    do_release(5, 9, 1, 1);
    lookup("R4", 4, tags(11, 0));
    do_write(8, 3, 1);
    lookup("R2", 7, tags(3, 0));
    do_release(9, 3, 0, 1);
    lookup("R4", 9, '0);
    lookup("R4", 7, tags(3, 0));
    counts("R6");
  endtask

  task automatic t_unmapped_r5;
    do_release(9, 3, 0, 0);
    do_release(12, 4, 1, 0);
    counts("R5");
    do_release(7, 6, 1, 1);
    lookup("R3", 7, tags(3, 0));
    counts("R5");
  endtask

  task automatic t_reserved_r9;
    do_write(0, 2, 1);
    do_write(10, 0, 1);
    do_release(0, 3, 1, 0);
    lookup("R9", 0, '0);
    lookup("R9", 10, '0);
    counts("R9");
  endtask

  task automatic t_peak_r6;
    do_write(10, 1, 0);
    do_write(11, 2, 0);
    do_write(12, 4, 0);
    do_write(1, 6, 0);
    counts("R6");
    lookup("R1", 1, tags(6, 0));
  endtask

  task automatic t_avail_r7;
    avail("R7", 1);
    avail("R7", 2);
    avail("R7", 8);
    avail("R7", 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_sub_r1;
    t_super_r2;
    t_release_r3;
    t_release_full_r4;
    t_unmapped_r5;
    t_reserved_r9;
    t_peak_r6;
    t_avail_r7;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule